// File: doc/BRIEF.md
# Dual-Mode Serial Port with Pad Release

This block moves words between a parallel host interface and three serial pins: transmit data, receive data and a serial clock. One configuration input selects its mode. In asynchronous mode it sends and receives framed characters (a low start bit, the data bits, a high stop bit) with no clock. The receiver oversamples the line 16 times per bit. In synchronous mode it is the clock master of a full-duplex shift: for every word it drives a burst of clock edges, shifts its own word out and captures the peer's word at the same time.

A programmable rate generator sets the bit timing in both modes. The word length, the bit order and the clock polarity are also selectable. The host writes words through a valid/ready handshake and reads received words the same way. A received word also carries a framing-error flag.

An availability input releases the clock and transmit pins: while it is low, both pins go to high impedance and a pad-enable output is low. A transfer already under way is frozen while the pins are released and goes on from the same point once availability returns.

Top module: `duplex_serial_port`

## Requirements
- R1: After reset, tx_ready is 1 (while avail is 1), rx_valid is 0, ser_txd is 1, ser_clk equals cfg_clk_pol, and pad_oe is 1.
- R2: The rate generator produces one tick every cfg_divider+1 clocks. In asynchronous mode one bit lasts 16 ticks, so the interval from acceptance to tx_ready rising again is between 16*(N+2)*(cfg_divider+1) - cfg_divider and 16*(N+2)*(cfg_divider+1) clocks, where N is the word length.
- R3: In asynchronous mode (cfg_sync = 0), an accepted word drives ser_txd low in the clock after the handshake and drops tx_ready at the same time. The frame is one low start bit, N data bits and one high stop bit.
- R4: The word length N is cfg_word_len clamped to the range 5..8 (values below 5 act as 5 and values above 8 act as 8). Transmit data bits at N and above are ignored. Received words are right-aligned in rx_data, with the bits at N and above set to zero.
- R5: With cfg_msb_first = 0, the first data bit on the line is bit 0. With cfg_msb_first = 1, it is bit N-1. The same order applies when receiving.
- R6: The asynchronous receiver accepts a start bit only if the line is still low 8 ticks after the first low sample. A low pulse shorter than that produces no word.
- R7: If the asynchronous receiver samples the stop bit low, it delivers the word with rx_frame_err = 1. A high stop bit gives rx_frame_err = 0.
- R8: In synchronous mode (cfg_sync = 1), each word produces 2N clock edges. The receive bit is sampled on each active edge, ser_txd changes only while the clock is at its idle level, and the captured peer word is delivered on rx_data.
- R9: The idle level of ser_clk equals cfg_clk_pol, and the active edge is the transition away from that level.
- R10: While avail is 0, pad_oe is 0, ser_txd and ser_clk are high impedance, tx_ready is 0, and a transfer in progress makes no progress. When avail returns, the transfer completes with the correct data.
- R11: rx_valid stays high, with rx_data and rx_frame_err unchanged, until a cycle in which rx_ready is 1. A word that completes while an earlier word is still pending is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_sync | input | 1 | 1 = synchronous clock-master mode, 0 = asynchronous framed mode |
| cfg_msb_first | input | 1 | 1 = most significant data bit first |
| cfg_clk_pol | input | 1 | Idle level of the serial clock |
| cfg_word_len | input | 4 | Requested data bits per word (clamped to 5..8) |
| cfg_divider | input | 16 | Rate generator: one tick every cfg_divider+1 clocks |
| avail | input | 1 | Pad availability; 0 releases ser_clk and ser_txd |
| tx_data | input | 8 | Word to transmit |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Port can accept a transmit word |
| rx_data | output | 8 | Received word, right-aligned |
| rx_valid | output | 1 | Received word pending |
| rx_ready | input | 1 | Host takes the pending word |
| rx_frame_err | output | 1 | Stop bit of the pending word was low |
| ser_rxd | input | 1 | Serial receive data |
| ser_txd | output | 1 | Serial transmit data (high impedance when released) |
| ser_clk | output | 1 | Serial clock (high impedance when released) |
| pad_oe | output | 1 | Output enable of the clock and transmit pads |

## Verification
A word is accepted on the clock edge where tx_valid and tx_ready are both high. ser_txd and tx_ready take their new values on that same edge, so the bench checks them at the falling edge just after. Line bits depend on ticks from a rate generator that keeps running between words, so an asynchronous frame starts up to one tick early relative to the word boundaries. The bench therefore samples each transmitted bit at its middle, a multiple of 16*(cfg_divider+1) clocks from acceptance, and checks that the frame length falls within a one-tick window. Received words reach the host a few clocks after the stop-bit sample (or after the last clock edge in synchronous mode), so a scoreboard queue compares them whenever rx_valid and rx_ready are both high rather than at a fixed cycle. The bench then confirms that the queue is empty a bit period later. The synchronous checks follow the clock pin edge by edge, acting as the peer device.

// File: rtl/sio_pkg.sv
package sio_pkg;

    localparam int WORD_W  = 8;
    localparam int WORD_MIN = 5;
    localparam int OVS     = 16;
    localparam int IDX_W   = $clog2(WORD_W);
    localparam int LEN_W   = $clog2(WORD_W + 2);

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_ASYNC,
        ENG_SYNC
    } eng_state_e;

    typedef enum logic [1:0] {
        RXS_IDLE,
        RXS_START,
        RXS_DATA,
        RXS_STOP
    } rx_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic              frame_err;
    } rx_word_t;

    function automatic logic [LEN_W-1:0] clamp_len(input logic [3:0] req);
        if (req < 4'(WORD_MIN)) return LEN_W'(WORD_MIN);
        if (req > 4'(WORD_W))   return LEN_W'(WORD_W);
        return LEN_W'(req);
    endfunction

    function automatic logic [IDX_W-1:0] slot_index(input logic msb_first,
                                                    input logic [LEN_W-1:0] idx,
                                                    input logic [LEN_W-1:0] len);
        logic [LEN_W-1:0] p;
        p = msb_first ? (len - LEN_W'(1) - idx) : idx;
        return p[IDX_W-1:0];
    endfunction

endpackage

// File: rtl/sio_rate_gen.sv
module sio_rate_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] divider,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = (cnt >= divider);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/sio_shift_engine.sv
module sio_shift_engine
    import sio_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int OS = OVS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             avail,
    input  logic             sync_mode,
    input  logic             msb_first,
    input  logic             clk_pol,
    input  logic [LEN_W-1:0] len,
    input  logic [W-1:0]     tx_data,
    input  logic             tx_valid,
    output logic             tx_ready,
    input  logic             rxd_raw,
    output logic             txd_q,
    output logic             clk_q,
    output logic             sync_done,
    output logic [W-1:0]     sync_word
);
    localparam int SUB_W = $clog2(OS);
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OS - 1);

    eng_state_e       state;
    logic [W-1:0]     shreg;
    logic [W-1:0]     rxbuf;
    logic [LEN_W-1:0] idx;
    logic [SUB_W-1:0] sub;
    logic             step;
    logic             accept;
    logic [LEN_W-1:0] nslot;
    logic             async_next_bit;
    logic             sync_next_bit;

    assign step     = tick & avail;
    assign tx_ready = (state == ENG_IDLE) & avail;
    assign accept   = tx_valid & tx_ready;
    assign nslot    = idx + 1'b1;

    // Line level for the next slot of an asynchronous frame:
    // slot 0 is the start bit, 1..len the data bits, len+1 the stop bit.
    always_comb begin
        if (nslot <= len)
            async_next_bit = shreg[slot_index(msb_first, nslot - 1'b1, len)];
        else
            async_next_bit = 1'b1;
        sync_next_bit = shreg[slot_index(msb_first, nslot, len)];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ENG_IDLE;
            shreg     <= '0;
            rxbuf     <= '0;
            idx       <= '0;
            sub       <= '0;
            txd_q     <= 1'b1;
            clk_q     <= clk_pol;
            sync_done <= 1'b0;
            sync_word <= '0;
        end else begin
            sync_done <= 1'b0;
            case (state)
                ENG_IDLE: begin
                    clk_q <= clk_pol;
                    txd_q <= 1'b1;
                    if (accept) begin
                        shreg <= tx_data;
                        rxbuf <= '0;
                        idx   <= '0;
                        sub   <= '0;
                        if (sync_mode) begin
                            state <= ENG_SYNC;
                            txd_q <= tx_data[slot_index(msb_first, '0, len)];
                        end else begin
                            state <= ENG_ASYNC;
                            txd_q <= 1'b0;
                        end
                    end
                end
                ENG_ASYNC: begin
                    if (step) begin
                        if (sub == SUB_LAST) begin
                            sub <= '0;
                            if (idx == len + 1'b1) begin
                                state <= ENG_IDLE;
                                txd_q <= 1'b1;
                            end else begin
                                idx   <= nslot;
                                txd_q <= async_next_bit;
                            end
                        end else begin
                            sub <= sub + 1'b1;
                        end
                    end
                end
                ENG_SYNC: begin
                    if (step) begin
                        if (!sub[0]) begin
                            // active edge: capture the peer's bit
                            clk_q <= ~clk_pol;
                            rxbuf[slot_index(msb_first, idx, len)] <= rxd_raw;
                            sub   <= SUB_W'(1);
                        end else begin
                            // inactive edge: present the next bit
                            clk_q <= clk_pol;
                            sub   <= '0;
                            if (idx == len - 1'b1) begin
                                state     <= ENG_IDLE;
                                txd_q     <= 1'b1;
                                sync_done <= 1'b1;
                                sync_word <= rxbuf;
                            end else begin
                                idx   <= nslot;
                                txd_q <= sync_next_bit;
                            end
                        end
                    end
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sio_async_rx.sv
module sio_async_rx
    import sio_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int OS = OVS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             tick,
    input  logic             rxd_pin,
    input  logic             msb_first,
    input  logic [LEN_W-1:0] len,
    output logic             done,
    output rx_word_t         word
);
    localparam int SUB_W = $clog2(OS);
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OS - 1);
    localparam logic [SUB_W-1:0] SUB_MID  = SUB_W'(OS / 2 - 1);

    rx_state_e        state;
    logic [1:0]       sync_ff;
    logic             rxd;
    logic [SUB_W-1:0] sub;
    logic [LEN_W-1:0] idx;
    logic [W-1:0]     buffer;

    assign rxd = sync_ff[1];

    always_ff @(posedge clk) begin
        if (rst) sync_ff <= 2'b11;
        else     sync_ff <= {sync_ff[0], rxd_pin};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= RXS_IDLE;
            sub    <= '0;
            idx    <= '0;
            buffer <= '0;
            done   <= 1'b0;
            word   <= '0;
        end else begin
            done <= 1'b0;
            if (!enable) begin
                state <= RXS_IDLE;
            end else if (tick) begin
                case (state)
                    RXS_IDLE: begin
                        if (!rxd) begin
                            state <= RXS_START;
                            sub   <= '0;
                        end
                    end
                    RXS_START: begin
                        if (sub == SUB_MID) begin
                            sub    <= '0;
                            idx    <= '0;
                            buffer <= '0;
                            state  <= rxd ? RXS_IDLE : RXS_DATA;
                        end else begin
                            sub <= sub + 1'b1;
                        end
                    end
                    RXS_DATA: begin
                        if (sub == SUB_LAST) begin
                            sub <= '0;
                            buffer[slot_index(msb_first, idx, len)] <= rxd;
                            idx <= idx + 1'b1;
                            if (idx == len - 1'b1) state <= RXS_STOP;
                        end else begin
                            sub <= sub + 1'b1;
                        end
                    end
                    RXS_STOP: begin
                        if (sub == SUB_LAST) begin
                            sub            <= '0;
                            state          <= RXS_IDLE;
                            done           <= 1'b1;
                            word.data      <= buffer;
                            word.frame_err <= ~rxd;
                        end else begin
                            sub <= sub + 1'b1;
                        end
                    end
                    default: state <= RXS_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/duplex_serial_port.sv
module duplex_serial_port
    import sio_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_sync,
    input  logic             cfg_msb_first,
    input  logic             cfg_clk_pol,
    input  logic [3:0]       cfg_word_len,
    input  logic [DIV_W-1:0] cfg_divider,
    input  logic             avail,
    input  logic [WORD_W-1:0] tx_data,
    input  logic             tx_valid,
    output logic             tx_ready,
    output logic [WORD_W-1:0] rx_data,
    output logic             rx_valid,
    input  logic             rx_ready,
    output logic             rx_frame_err,
    input  logic             ser_rxd,
    output logic             ser_txd,
    output logic             ser_clk,
    output logic             pad_oe
);
    logic             bit_tick;
    logic             eng_txd;
    logic             eng_clk;
    logic [LEN_W-1:0] len;
    logic             sync_done;
    logic [WORD_W-1:0] sync_word;
    logic             arx_done;
    rx_word_t         arx_word;
    rx_word_t         hold_q;
    logic             hold_valid;

    assign len = clamp_len(cfg_word_len);

    sio_rate_gen #(.DIV_W(DIV_W)) u_rate (
        .clk     (clk),
        .rst     (rst),
        .divider (cfg_divider),
        .tick    (bit_tick)
    );

    sio_shift_engine #(.W(WORD_W), .OS(OVS)) u_engine (
        .clk       (clk),
        .rst       (rst),
        .tick      (bit_tick),
        .avail     (avail),
        .sync_mode (cfg_sync),
        .msb_first (cfg_msb_first),
        .clk_pol   (cfg_clk_pol),
        .len       (len),
        .tx_data   (tx_data),
        .tx_valid  (tx_valid),
        .tx_ready  (tx_ready),
        .rxd_raw   (ser_rxd),
        .txd_q     (eng_txd),
        .clk_q     (eng_clk),
        .sync_done (sync_done),
        .sync_word (sync_word)
    );

    sio_async_rx #(.W(WORD_W), .OS(OVS)) u_arx (
        .clk       (clk),
        .rst       (rst),
        .enable    (~cfg_sync),
        .tick      (bit_tick),
        .rxd_pin   (ser_rxd),
        .msb_first (cfg_msb_first),
        .len       (len),
        .done      (arx_done),
        .word      (arx_word)
    );

    // Host-side receive holding register: first completed word wins.
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_valid <= 1'b0;
            hold_q     <= '0;
        end else if (hold_valid) begin
            if (rx_ready) begin
                hold_valid       <= 1'b0;
                hold_q.frame_err <= 1'b0;
            end
        end else if (sync_done) begin
            hold_valid <= 1'b1;
            hold_q     <= '{data: sync_word, frame_err: 1'b0};
        end else if (arx_done) begin
            hold_valid <= 1'b1;
            hold_q     <= arx_word;
        end
    end

    assign rx_valid     = hold_valid;
    assign rx_data      = hold_q.data;
    assign rx_frame_err = hold_q.frame_err;

    assign pad_oe  = avail;
    assign ser_txd = avail ? eng_txd : 1'bz;
    assign ser_clk = avail ? eng_clk : 1'bz;
endmodule

// File: rtl/duplex_serial_port_chk.sv
module sio_port_chk #(
    parameter int DIV_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             avail,
    input logic             cfg_sync,
    input logic             cfg_clk_pol,
    input logic [DIV_W-1:0] cfg_divider,
    input logic             tx_valid,
    input logic             tx_ready,
    input logic             rx_valid,
    input logic             rx_ready,
    input logic [7:0]       rx_data,
    input logic             rx_frame_err,
    input logic             bit_tick,
    input logic             eng_txd,
    input logic             eng_clk
);
    logic [DIV_W:0]   gap;
    logic             armed;
    logic [DIV_W-1:0] prev_div;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap      <= '0;
            armed    <= 1'b0;
            prev_div <= cfg_divider;
        end else begin
            prev_div <= cfg_divider;
            if (bit_tick) begin
                gap   <= '0;
                armed <= (cfg_divider == prev_div);
            end else begin
                gap <= gap + 1'b1;
                if (cfg_divider != prev_div) armed <= 1'b0;
            end
        end
    end

    // R2: tick spacing equals divider + 1
    a_r2_tick_period: assert property (@(posedge clk) disable iff (rst)
        (armed && bit_tick && cfg_divider == prev_div) |-> (gap == {1'b0, cfg_divider}));

    // R3: acceptance makes the port busy in the next cycle
    a_r3_accept_busy: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready) |=> !tx_ready);

    // R7: a framing error is only reported with a pending word
    a_r7_err_with_word: assert property (@(posedge clk) disable iff (rst)
        rx_frame_err |-> rx_valid);

    // R8: transmit data holds while the clock is at its active level
    a_r8_data_stable_active: assert property (@(posedge clk) disable iff (rst)
        (cfg_sync && $stable(cfg_clk_pol) && eng_clk != cfg_clk_pol
         && $past(eng_clk) != cfg_clk_pol) |-> $stable(eng_txd));

    // R9: an idle port rests its clock at the polarity level
    a_r9_idle_level: assert property (@(posedge clk) disable iff (rst)
        (tx_ready && $stable(cfg_clk_pol)) |-> (eng_clk == cfg_clk_pol));

    // R10: released pads freeze the line state
    a_r10_frozen: assert property (@(posedge clk) disable iff (rst)
        (!avail && $stable(cfg_clk_pol)) |=> ($stable(eng_txd) && $stable(eng_clk)));

    // R11: a pending word is held until taken
    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data) && $stable(rx_frame_err)));
endmodule

bind duplex_serial_port sio_port_chk #(.DIV_W(DIV_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .avail        (avail),
    .cfg_sync     (cfg_sync),
    .cfg_clk_pol  (cfg_clk_pol),
    .cfg_divider  (cfg_divider),
    .tx_valid     (tx_valid),
    .tx_ready     (tx_ready),
    .rx_valid     (rx_valid),
    .rx_ready     (rx_ready),
    .rx_data      (rx_data),
    .rx_frame_err (rx_frame_err),
    .bit_tick     (bit_tick),
    .eng_txd      (eng_txd),
    .eng_clk      (eng_clk)
);

// File: tb/duplex_serial_port_tb.sv
module duplex_serial_port_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_sync = 1'b0;
    logic        cfg_msb_first = 1'b0;
    logic        cfg_clk_pol = 1'b0;
    logic [3:0]  cfg_word_len = 4'd8;
    logic [15:0] cfg_divider = 16'd1;
    logic        avail = 1'b1;
    logic [7:0]  tx_data = 8'h00;
    logic        tx_valid = 1'b0;
    logic        tx_ready;
    logic [7:0]  rx_data;
    logic        rx_valid;
    logic        rx_ready = 1'b1;
    logic        rx_frame_err;
    logic        loop_en = 1'b1;
    logic        drv_rxd = 1'b1;
    logic        ser_rxd;
    logic        ser_txd;
    logic        ser_clk;
    logic        pad_oe;

    int n_total = 0;
    int n_fail  = 0;
    int rx_seen = 0;
    int cyc     = 0;
    bit done    = 1'b0;

    logic [8:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign ser_rxd = loop_en ? ser_txd : drv_rxd;

    duplex_serial_port u_dut (
        .clk (clk), .rst (rst),
        .cfg_sync (cfg_sync), .cfg_msb_first (cfg_msb_first),
        .cfg_clk_pol (cfg_clk_pol), .cfg_word_len (cfg_word_len),
        .cfg_divider (cfg_divider), .avail (avail),
        .tx_data (tx_data), .tx_valid (tx_valid), .tx_ready (tx_ready),
        .rx_data (rx_data), .rx_valid (rx_valid), .rx_ready (rx_ready),
        .rx_frame_err (rx_frame_err), .ser_rxd (ser_rxd),
        .ser_txd (ser_txd), .ser_clk (ser_clk), .pad_oe (pad_oe)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int eff_len(input logic [3:0] req);
        if (req < 4'd5) return 5;
        if (req > 4'd8) return 8;
        return int'(req);
    endfunction

    function automatic logic [7:0] mask_word(input logic [7:0] w, input int n);
        return w & 8'((1 << n) - 1);
    endfunction

    function automatic logic [7:0] line_seq(input logic [7:0] w, input int n, input bit msb);
        logic [7:0] s = '0;
        for (int i = 0; i < n; i++) s[i] = msb ? w[n-1-i] : w[i];
        return s;
    endfunction

    task automatic expect_rx(input logic [7:0] d, input logic e, input string tag);
        exp_q.push_back({d, e});
        tag_q.push_back(tag);
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && rx_valid && rx_ready) begin
            rx_seen++;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R11", "unexpected word", int'(rx_data), 0);
            end else begin
                logic [8:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(rx_data == e[8:1], t, "rx_data", int'(rx_data), int'(e[8:1]));
                chk(rx_frame_err == e[0], t, "rx_frame_err", int'(rx_frame_err), int'(e[0]));
            end
        end
    end

    task automatic send_word(input logic [7:0] w);
        @(negedge clk);
        while (!tx_ready) @(negedge clk);
        tx_data  = w;
        tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    // Asynchronous transmit with loopback, line decode and frame length
    task automatic async_tx(input logic [7:0] w, input bit push, input string tag);
        int n, p, d1, c0, len_cyc;
        logic [7:0] seq;
        n  = eff_len(cfg_word_len);
        d1 = int'(cfg_divider) + 1;
        p  = 16 * d1;
        if (push) expect_rx(mask_word(w, n), 1'b0, tag);
        send_word(w);
        c0 = cyc;
        chk(ser_txd == 1'b0, "R3", "start bit after accept", int'(ser_txd), 0);
        chk(tx_ready == 1'b0, "R3", "busy after accept", int'(tx_ready), 0);
        repeat (p / 2) @(negedge clk);
        chk(ser_txd == 1'b0, "R3", "mid start bit", int'(ser_txd), 0);
        seq = '0;
        for (int i = 0; i < n; i++) begin
            repeat (p) @(negedge clk);
            seq[i] = ser_txd;
        end
        repeat (p) @(negedge clk);
        chk(ser_txd == 1'b1, "R3", "stop bit", int'(ser_txd), 1);
        chk(seq == line_seq(w, n, cfg_msb_first), tag, "line bit order",
            int'(seq), int'(line_seq(w, n, cfg_msb_first)));
        while (!tx_ready) @(negedge clk);
        len_cyc = cyc - c0;
        chk(len_cyc >= 16 * (n + 2) * d1 - d1 + 1 && len_cyc <= 16 * (n + 2) * d1,
            "R2", "frame length", len_cyc, 16 * (n + 2) * d1);
        repeat (p) @(negedge clk);
    endtask

    // Drive an asynchronous frame into the receiver
    task automatic drive_frame(input logic [7:0] w, input logic stop, input string tag);
        int n, p;
        logic [7:0] seq;
        n   = eff_len(cfg_word_len);
        p   = 16 * (int'(cfg_divider) + 1);
        seq = line_seq(w, n, cfg_msb_first);
        expect_rx(mask_word(w, n), ~stop, tag);
        @(negedge clk);
        drv_rxd = 1'b0;
        repeat (p) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            drv_rxd = seq[i];
            repeat (p) @(negedge clk);
        end
        drv_rxd = stop;
        repeat (p) @(negedge clk);
        drv_rxd = 1'b1;
        repeat (2 * p) @(negedge clk);
        chk(exp_q.size() == 0, tag, "word delivered", exp_q.size(), 0);
    endtask

    // Synchronous transfer with the bench as the peer
    task automatic sync_xfer(input logic [7:0] mw, input logic [7:0] sw,
                             input int hold_after, input string tag);
        int n, edges, act, guard;
        bit held;
        logic pol, prev;
        logic [7:0] sseq, got;
        n     = eff_len(cfg_word_len);
        pol   = cfg_clk_pol;
        sseq  = line_seq(sw, n, cfg_msb_first);
        got   = '0;
        edges = 0;
        act   = 0;
        held  = 1'b0;
        guard = 0;
        prev  = pol;
        expect_rx(mask_word(sw, n), 1'b0, tag);
        drv_rxd = sseq[0];
        send_word(mw);
        while (edges < 2 * n && guard < 20000) begin
            @(negedge clk);
            guard++;
            if (pad_oe && ser_clk != prev) begin
                prev = ser_clk;
                edges++;
                if (ser_clk != pol) begin
                    got[act] = ser_txd;
                    act++;
                end else if (act < n) begin
                    drv_rxd = sseq[act];
                end
            end
            if (hold_after >= 0 && !held && act == hold_after && prev == pol) begin
                held  = 1'b1;
                avail = 1'b0;
                repeat (2) @(negedge clk);
                chk(pad_oe == 1'b0, "R10", "pad released", int'(pad_oe), 0);
                chk(tx_ready == 1'b0, "R10", "no accept while released", int'(tx_ready), 0);
                repeat (40) @(negedge clk);
                chk(rx_seen >= 0 && exp_q.size() == 1, "R10", "transfer frozen",
                    exp_q.size(), 1);
                avail = 1'b1;
            end
        end
        chk(edges == 2 * n, "R8", "clock edge count", edges, 2 * n);
        chk(got == line_seq(mw, n, cfg_msb_first), tag, "master bits on line",
            int'(got), int'(line_seq(mw, n, cfg_msb_first)));
        repeat (4) @(negedge clk);
        chk(ser_clk == pol, "R9", "clock idle level", int'(ser_clk), int'(pol));
        chk(exp_q.size() == 0, tag, "peer word delivered", exp_q.size(), 0);
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        int seen0;
        logic [7:0] held_data;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(tx_ready == 1'b1, "R1", "tx_ready", int'(tx_ready), 1);
        chk(rx_valid == 1'b0, "R1", "rx_valid", int'(rx_valid), 0);
        chk(ser_txd == 1'b1, "R1", "ser_txd idle", int'(ser_txd), 1);
        chk(ser_clk == cfg_clk_pol, "R1", "ser_clk idle", int'(ser_clk), int'(cfg_clk_pol));
        chk(pad_oe == 1'b1, "R1", "pad_oe", int'(pad_oe), 1);

        // R3/R5 LSB first, 8 bits, divider 1
        async_tx(8'hA5, 1'b1, "R5");
        async_tx(8'h38, 1'b1, "R3");
        // R5 MSB first, divider 2
        cfg_msb_first = 1'b1;
        cfg_divider   = 16'd2;
        async_tx(8'h1E, 1'b1, "R5");
        // R4 five bits, upper bits ignored
        cfg_msb_first = 1'b0;
        cfg_divider   = 16'd1;
        cfg_word_len  = 4'd5;
        async_tx(8'hFF, 1'b1, "R4");
        cfg_word_len  = 4'd2;
        async_tx(8'hE9, 1'b1, "R4");
        cfg_word_len  = 4'd8;

        // R6 short glitch rejected
        loop_en = 1'b0;
        seen0 = rx_seen;
        @(negedge clk);
        drv_rxd = 1'b0;
        repeat (6) @(negedge clk);
        drv_rxd = 1'b1;
        repeat (120) @(negedge clk);
        chk(rx_seen == seen0 && rx_valid == 1'b0, "R6", "glitch gives no word",
            rx_seen - seen0, 0);
        drive_frame(8'h6C, 1'b1, "R6");

        // R7 framing error, then a clean frame
        drive_frame(8'h93, 1'b0, "R7");
        cfg_msb_first = 1'b1;
        drive_frame(8'h4B, 1'b1, "R7");
        cfg_msb_first = 1'b0;

        // R11 pending word held, later word dropped
        loop_en  = 1'b1;
        rx_ready = 1'b0;
        seen0    = rx_seen;
        async_tx(8'h5D, 1'b1, "R11");
        chk(rx_valid == 1'b1, "R11", "word pending", int'(rx_valid), 1);
        held_data = rx_data;
        repeat (20) @(negedge clk);
        chk(rx_valid == 1'b1 && rx_data == held_data, "R11", "pending word held",
            int'(rx_data), int'(held_data));
        async_tx(8'h22, 1'b0, "R11");
        chk(rx_data == 8'h5D, "R11", "later word discarded", int'(rx_data), 8'h5D);
        rx_ready = 1'b1;
        repeat (4) @(negedge clk);
        chk(rx_seen == seen0 + 1 && rx_valid == 1'b0, "R11", "single delivery",
            rx_seen - seen0, 1);

        // R8 synchronous, polarity 0, LSB first
        loop_en     = 1'b0;
        cfg_sync    = 1'b1;
        cfg_divider = 16'd0;
        repeat (4) @(negedge clk);
        sync_xfer(8'hC3, 8'h5A, -1, "R8");
        cfg_divider = 16'd3;
        sync_xfer(8'h81, 8'h7E, -1, "R8");

        // R9 polarity 1, MSB first, six bits
        cfg_clk_pol   = 1'b1;
        cfg_msb_first = 1'b1;
        cfg_word_len  = 4'd6;
        repeat (4) @(negedge clk);
        chk(ser_clk == 1'b1, "R9", "idle high", int'(ser_clk), 1);
        sync_xfer(8'hED, 8'h96, -1, "R9");

        // R10 release pads mid-transfer
        cfg_clk_pol   = 1'b0;
        cfg_msb_first = 1'b0;
        cfg_word_len  = 4'd8;
        cfg_divider   = 16'd1;
        repeat (4) @(negedge clk);
        sync_xfer(8'h3A, 8'hC5, 3, "R10");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule